// File: doc/BRIEF.md
# Command/Address Pipeline Register

This block sits on a memory module between the controller's command pins and the SDRAM devices. It forwards the row/column address, the bank select, the per-rank chip selects, the three command strobes (RAS, CAS, WE), the clock enable and the per-lane byte masks to the devices. A static mode input selects one of two behaviours. In registered operation every control and address signal is captured on a rising edge and driven to the devices from the next edge, so it arrives one cycle late and stays steady for a whole cycle. In buffered operation the signals pass straight through with no added cycle. The data bus is not part of this block.

The block also produces a per-lane read output enable. It is the byte mask realigned to the read timing of the selected mode. In registered operation a mask bit takes effect on read data three clocks after it is sampled. In buffered operation it takes effect two clocks after it is sampled. The write mask seen by the devices has one clock of latency in registered operation and none in buffered operation. While reset is applied in registered operation, the devices see a deselected, idle command.

Top module: `ca_cmd_pipe`

## Requirements
- R1: With `regEnable` high, `devAddr`, `devBank`, `devCsN`, `devRasN`, `devCasN`, `devWeN` and `devCke` equal the values their `ca*` inputs had at the previous rising edge. They do not change between edges.
- R2: With `regEnable` low, each `dev*` command and address output equals its `ca*` input in the same cycle.
- R3: While `rstN` is low in registered mode, the outputs show the idle state. All `devCsN` bits are 1, `devRasN`/`devCasN`/`devWeN` are 1, `devCke` is 1, `devAddr` and `devBank` are 0, and all `devMask` bits are 1.
- R4: With `regEnable` high, `devMask` (the write byte mask; 1 blocks the byte) equals `caMask` as sampled at the previous rising edge.
- R5: With `regEnable` low, `devMask` equals `caMask` in the same cycle.
- R6: With `regEnable` high, `rdLaneEn` equals the bitwise inverse of `caMask` as sampled three rising edges earlier.
- R7: With `regEnable` low, `rdLaneEn` equals the bitwise inverse of `caMask` as sampled two rising edges earlier.
- R8: Mask bit i governs byte lane i alone. Bits 0 to 7 cover data bits 8i+7..8i, and bit 8 covers the eight check bits. A single set mask bit clears only the matching `rdLaneEn` bit.
- R9: `rdLaneEn` is all zero during reset. It stays all zero until every stage of the mask delay line has been filled after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| regEnable | input | 1 | 1 = registered operation, 0 = buffered pass-through; static |
| caAddr | input | 13 | Row/column address from the controller |
| caBank | input | 2 | Device bank select |
| caCsN | input | 4 | Chip selects, active low, one per rank |
| caRasN | input | 1 | Row strobe, active low |
| caCasN | input | 1 | Column strobe, active low |
| caWeN | input | 1 | Write strobe, active low |
| caCke | input | 1 | Clock enable, active high |
| caMask | input | 9 | Byte masks, one per lane, 1 = masked |
| devAddr | output | 13 | Address to the devices |
| devBank | output | 2 | Bank select to the devices |
| devCsN | output | 4 | Chip selects to the devices |
| devRasN | output | 1 | Row strobe to the devices |
| devCasN | output | 1 | Column strobe to the devices |
| devWeN | output | 1 | Write strobe to the devices |
| devCke | output | 1 | Clock enable to the devices |
| devMask | output | 9 | Write byte mask to the devices |
| rdLaneEn | output | 9 | Per-lane read output enable, 1 = lane drives |

## Verification
On every cycle, the bound checker compares the device-side outputs with the controller inputs one edge back (registered) or in the same cycle (buffered). It also compares the read lane enables with the mask three or two edges back, and holds the idle command while reset is applied in registered mode. Only the bench scenarios can show the fill of the mask delay line after reset, the lane independence under a walking mask, and both modes running after a fresh reset. They use a reference history that knows nothing of the design's registers.

// File: rtl/ca_pipe_pkg.sv
package ca_pipe_pkg;

  // Strobes from the mode control to the datapath.
  typedef struct packed {
    logic holdRegistered;  // drive devices from the capture register
    logic deepReadTap;     // take the read enable from the longer tap
  } caStrobes_t;

endpackage

// File: rtl/ca_pipe_ctrl.sv
module ca_pipe_ctrl
  import ca_pipe_pkg::*;
(
  input  logic       regEnable,
  output caStrobes_t strobes
);

  // The mode pin is static. Both strobes follow it directly, so the
  // command path and the read mask tap always move together.
  always_comb begin
    strobes.holdRegistered = regEnable;
    strobes.deepReadTap    = regEnable;
  end

endmodule

// File: rtl/ca_pipe_datapath.sv
module ca_pipe_datapath
  import ca_pipe_pkg::*;
#(
  parameter int CMD_W      = 23,
  parameter int ADDR_BITS  = 15,
  parameter int LANES      = 9,
  parameter int RD_LAT_BUF = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  caStrobes_t       strobes,
  input  logic [CMD_W-1:0] cmdIn,
  input  logic [LANES-1:0] maskIn,
  output logic [CMD_W-1:0] cmdOut,
  output logic [LANES-1:0] maskOut,
  output logic [LANES-1:0] rdLaneEn
);

  localparam int RD_LAT_REG = RD_LAT_BUF + 1;
  // Idle: address and bank zero, every active-low strobe and the clock enable at one.
  localparam logic [CMD_W-1:0] CMD_IDLE = {{ADDR_BITS{1'b0}}, {(CMD_W-ADDR_BITS){1'b1}}};

  logic [CMD_W-1:0]                  cmdQ;
  logic [RD_LAT_REG-1:0][LANES-1:0]  maskPipe;
  logic [LANES-1:0]                  rdMaskTap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmdQ <= CMD_IDLE;
    else       cmdQ <= cmdIn;
  end

  // Stage 0 is the mask capture register. The later stages realign the mask for reads.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskPipe <= '1;
    end else begin
      maskPipe[0] <= maskIn;
      for (int s = 1; s < RD_LAT_REG; s++) maskPipe[s] <= maskPipe[s-1];
    end
  end

  always_comb begin
    cmdOut    = strobes.holdRegistered ? cmdQ        : cmdIn;
    maskOut   = strobes.holdRegistered ? maskPipe[0] : maskIn;
    rdMaskTap = strobes.deepReadTap ? maskPipe[RD_LAT_REG-1] : maskPipe[RD_LAT_BUF-1];
  end

  genvar lane;
  generate
    for (lane = 0; lane < LANES; lane++) begin : g_lane
      assign rdLaneEn[lane] = ~rdMaskTap[lane];
    end
  endgenerate

endmodule

// File: rtl/ca_cmd_pipe.sv
module ca_cmd_pipe
  import ca_pipe_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int BANK_W     = 2,
  parameter int CS_W       = 4,
  parameter int LANES      = 9,
  parameter int RD_LAT_BUF = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regEnable,
  input  logic [ADDR_W-1:0] caAddr,
  input  logic [BANK_W-1:0] caBank,
  input  logic [CS_W-1:0]   caCsN,
  input  logic              caRasN,
  input  logic              caCasN,
  input  logic              caWeN,
  input  logic              caCke,
  input  logic [LANES-1:0]  caMask,
  output logic [ADDR_W-1:0] devAddr,
  output logic [BANK_W-1:0] devBank,
  output logic [CS_W-1:0]   devCsN,
  output logic              devRasN,
  output logic              devCasN,
  output logic              devWeN,
  output logic              devCke,
  output logic [LANES-1:0]  devMask,
  output logic [LANES-1:0]  rdLaneEn
);

  localparam int CMD_W = ADDR_W + BANK_W + CS_W + 4;

  caStrobes_t       strobes;
  logic [CMD_W-1:0] cmdIn;
  logic [CMD_W-1:0] cmdOut;

  assign cmdIn = {caAddr, caBank, caCsN, caRasN, caCasN, caWeN, caCke};
  assign {devAddr, devBank, devCsN, devRasN, devCasN, devWeN, devCke} = cmdOut;

  ca_pipe_ctrl i_ctrl (
    .regEnable (regEnable),
    .strobes   (strobes)
  );

  ca_pipe_datapath #(
    .CMD_W      (CMD_W),
    .ADDR_BITS  (ADDR_W + BANK_W),
    .LANES      (LANES),
    .RD_LAT_BUF (RD_LAT_BUF)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cmdIn    (cmdIn),
    .maskIn   (caMask),
    .cmdOut   (cmdOut),
    .maskOut  (devMask),
    .rdLaneEn (rdLaneEn)
  );

endmodule

// File: rtl/ca_pipe_checker.sv
module ca_pipe_checker #(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2,
  parameter int CS_W   = 4,
  parameter int LANES  = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              regEnable,
  input logic [ADDR_W-1:0] caAddr,
  input logic [BANK_W-1:0] caBank,
  input logic [CS_W-1:0]   caCsN,
  input logic              caRasN,
  input logic              caCasN,
  input logic              caWeN,
  input logic              caCke,
  input logic [LANES-1:0]  caMask,
  input logic [ADDR_W-1:0] devAddr,
  input logic [BANK_W-1:0] devBank,
  input logic [CS_W-1:0]   devCsN,
  input logic              devRasN,
  input logic              devCasN,
  input logic              devWeN,
  input logic              devCke,
  input logic [LANES-1:0]  devMask,
  input logic [LANES-1:0]  rdLaneEn
);

  assert_reg_cmd_R1: assert property (@(posedge clk) disable iff (!rstN)
    (regEnable && $past(rstN)) |->
      {devAddr, devBank, devCsN, devRasN, devCasN, devWeN, devCke} ==
      $past({caAddr, caBank, caCsN, caRasN, caCasN, caWeN, caCke}));

  assert_buf_cmd_R2: assert property (@(posedge clk) disable iff (!rstN)
    !regEnable |->
      {devAddr, devBank, devCsN, devRasN, devCasN, devWeN, devCke} ==
      {caAddr, caBank, caCsN, caRasN, caCasN, caWeN, caCke});

  assert_reset_idle_R3: assert property (@(posedge clk)
    (!rstN && regEnable) |->
      (devCsN == '1 && devRasN && devCasN && devWeN && devCke && devMask == '1));

  assert_reg_wmask_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regEnable && $past(rstN)) |-> devMask == $past(caMask));

  assert_buf_wmask_R5: assert property (@(posedge clk) disable iff (!rstN)
    !regEnable |-> devMask == caMask);

  assert_reg_rdlane_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regEnable && $past(rstN) && $past(rstN, 2) && $past(rstN, 3)) |->
      rdLaneEn == ~$past(caMask, 3));

  assert_buf_rdlane_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!regEnable && $past(rstN) && $past(rstN, 2)) |->
      rdLaneEn == ~$past(caMask, 2));

endmodule

bind ca_cmd_pipe ca_pipe_checker #(
  .ADDR_W (ADDR_W),
  .BANK_W (BANK_W),
  .CS_W   (CS_W),
  .LANES  (LANES)
) i_ca_pipe_checker (.*);

// File: tb/test_ca_cmd_pipe.sv
`timescale 1ns/1ps
module test_ca_cmd_pipe;

  // Vector layout: {addr[12:0], bank[1:0], csN[3:0], rasN, casN, weN, cke, mask[8:0]}
  typedef struct {
    logic [31:0] v;
    bit          ok;   // reset was released when this vector was applied
  } entry_t;

  localparam logic [22:0] CMD_IDLE = {15'h0, 8'hFF};

  logic        clk = 1'b0;
  logic        rstN;
  logic        regEnable;
  logic [31:0] vin;
  logic [12:0] devAddr;
  logic [1:0]  devBank;
  logic [3:0]  devCsN;
  logic        devRasN, devCasN, devWeN, devCke;
  logic [8:0]  devMask, rdLaneEn;

  int     checks = 0;
  int     failures = 0;
  bit     rstNext = 1'b0;
  bit     walking = 1'b0;
  bit     finished = 1'b0;
  entry_t q[$];
  entry_t hist[4];

  always #4 clk = ~clk;

  ca_cmd_pipe i_ca_cmd_pipe (
    .clk       (clk),
    .rstN      (rstN),
    .regEnable (regEnable),
    .caAddr    (vin[31:19]),
    .caBank    (vin[18:17]),
    .caCsN     (vin[16:13]),
    .caRasN    (vin[12]),
    .caCasN    (vin[11]),
    .caWeN     (vin[10]),
    .caCke     (vin[9]),
    .caMask    (vin[8:0]),
    .devAddr   (devAddr),
    .devBank   (devBank),
    .devCsN    (devCsN),
    .devRasN   (devRasN),
    .devCasN   (devCasN),
    .devWeN    (devWeN),
    .devCke    (devCke),
    .devMask   (devMask),
    .rdLaneEn  (rdLaneEn)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s at %0t: got %h expected %h", tag, $time, got, exp);
    end
  endtask

  // Driver: one vector per cycle, applied just after the rising edge, pushed to the scoreboard.
  task automatic step(input logic [31:0] v);
    entry_t e;
    @(posedge clk);
    #1;
    rstN = rstNext;
    vin  = v;
    e.v  = v;
    e.ok = rstNext;
    q.push_back(e);
  endtask

  // Monitor: mid-cycle, pops the vector of this cycle and compares against the history.
  always @(negedge clk) begin
    if (q.size() != 0) begin
      logic [22:0] cmdExp;
      logic [8:0]  maskExp, rdExp;
      bit          regOk, rdOk;
      string       cmdTag, maskTag, rdTag;
      hist[3] = hist[2];
      hist[2] = hist[1];
      hist[1] = hist[0];
      hist[0] = q.pop_front();
      if (regEnable) begin
        regOk   = hist[0].ok && hist[1].ok;
        cmdExp  = regOk ? hist[1].v[31:9] : CMD_IDLE;
        maskExp = regOk ? hist[1].v[8:0] : 9'h1FF;
        cmdTag  = regOk ? "R1" : "R3";
        maskTag = regOk ? "R4" : "R3";
        rdOk    = regOk && hist[2].ok && hist[3].ok;
        rdExp   = rdOk ? ~hist[3].v[8:0] : 9'h000;
        rdTag   = !rdOk ? "R9" : (walking ? "R8" : "R6");
      end else begin
        cmdExp  = hist[0].v[31:9];
        maskExp = hist[0].v[8:0];
        cmdTag  = "R2";
        maskTag = "R5";
        rdOk    = hist[0].ok && hist[1].ok && hist[2].ok;
        rdExp   = rdOk ? ~hist[2].v[8:0] : 9'h000;
        rdTag   = !rdOk ? "R9" : (walking ? "R8" : "R7");
      end
      check(cmdTag, {9'h0, devAddr, devBank, devCsN, devRasN, devCasN, devWeN, devCke}, {9'h0, cmdExp});
      check(maskTag, {23'h0, devMask}, {23'h0, maskExp});
      check(rdTag, {23'h0, rdLaneEn}, {23'h0, rdExp});
    end
  end

  task automatic runPhase();
    // Inputs under reset must not reach the registered outputs (R3) or read enables (R9).
    rstNext = 1'b0;
    for (int i = 0; i < 3; i++) step($urandom);
    rstNext = 1'b1;
    // Walking single masked lane, including the check-bit lane 8 (R8).
    walking = 1'b1;
    for (int i = 0; i < 9; i++) step({23'h0AAAAA ^ 23'(i), 9'(1 << i)});
    for (int i = 0; i < 3; i++) step({23'h0AAAAA, 9'h000});
    walking = 1'b0;
    // Mixed traffic (R1, R2, R4..R7).
    for (int i = 0; i < 40; i++) step($urandom);
    // Held vector: outputs must stay steady.
    for (int i = 0; i < 4; i++) step(32'h5A5A_C3C3);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) begin
      hist[i].v  = '0;
      hist[i].ok = 1'b0;
    end
    vin       = '0;
    regEnable = 1'b1;
    rstN      = 1'b1;
    #1 rstN   = 1'b0;
    runPhase();
    // Switch to buffered operation under a fresh reset.
    rstNext = 1'b0;
    step($urandom);
    regEnable = 1'b0;
    runPhase();
    rstNext = 1'b1;
    for (int i = 0; i < 4; i++) step($urandom);
    @(posedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule